// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a flow-through synchronous burst static RAM with a small parameterized storage array. On every rising clock edge it samples two address strobes, a burst-advance input, three chip-select inputs, a write-enable group, the address and the write data. From these it decides whether the cycle starts a burst from the external address, continues a burst, holds a burst, deselects the device, or does nothing.

A two-bit burst counter walks through the four words of an aligned group in either interleaved or linear order, chosen by a static mode input. Writes can cover the whole word or any set of byte lanes. Read data appears in the same cycle as the address it belongs to, with no extra pipeline register. It is presented on a separate read bus together with a valid flag that an asynchronous output-enable input gates. A sleep input freezes the whole block, storage included, until it is released.

The control follows a two-state machine. `ST_DESEL` is entered from reset and through the deselect transition. `ST_BURST` is entered through the begin transition. In `ST_BURST`, the continue transition advances or holds the counter, the deselect transition returns to `ST_DESEL`, and a no-op cycle leaves the state unchanged.

Top module: `bsram_core`

## Requirements
- R1: A begin cycle takes place when the device is selected (`cs1_n` low, `cs2` high, `cs3_n` low) and either `proc_stb_n` is low, or `proc_stb_n` is high and `ctrl_stb_n` is low. It loads the external address, and that cycle accesses that address.
- R2: A begin cycle with `proc_stb_n` low is always a read, whatever the write enables show. A begin cycle through `ctrl_stb_n` writes when the write condition holds, and reads otherwise.
- R3: The cycle is a deselect when the device is not selected and either `ctrl_stb_n` is low, or `proc_stb_n` is low while `cs1_n` is low. After a deselect, every cycle with both strobes high does no access, and `rd_valid` stays low until the next begin cycle.
- R4: With `proc_stb_n` low, `cs1_n` high and `ctrl_stb_n` high, the cycle performs no access and leaves the burst position unchanged.
- R5: In a burst, a cycle with both strobes high advances the burst position when `adv_n` is low and holds it when `adv_n` is high, whatever the chip-select levels are. The cycle reads or writes according to the write condition.
- R6: Within a burst only address bits [1:0] change; the upper bits keep the value loaded at the begin cycle.
- R7: With `burst_ilv` high, step n (n = 0 to 3) uses low bits equal to the start low bits XOR n. With `burst_ilv` low, it uses the start low bits plus n, modulo 4.
- R8: The write condition holds when `wr_all_n` is low, which writes all lanes, or when `wr_gate_n` is low and at least one `lane_wr_n[i]` is low, which writes only those lanes. Lane i is data bits [8i+7:8i].
- R9: Reads are flow-through: after the edge that registers a read, `rdata` shows the stored word at that address. `rd_valid` is high only during a read cycle while `oe_n` is low, and `oe_n` acts without a clock. `rdata` is zero whenever `rd_valid` is low.
- R10: While `sleep` is high, all synchronous inputs are ignored, the stored data, the address and the burst state are held, and `rd_valid` is low. Normal operation resumes when `sleep` falls.
- R11: After reset the block is deselected and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_stb_n | input | 1 | Processor-side address strobe, active low, higher priority |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_gate_n | input | 1 | Byte-write gate, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Freeze request, active high |
| addr | input | ADDR_W | External word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read data is being driven |

## Verification
Sleep can fall in the same cycle as any burst command: a begin, a deselect, an advance or a byte write. The sleep input must win over all of them. The bench provokes this by raising `sleep` at random in random command streams, and by a directed case that presents a processor begin and an advance while asleep. Each cycle is judged against a bench model that leaves its state, address and storage untouched while asleep, and the first advance after waking must continue from the position reached before the sleep.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_RD   = 2'd1,
        CYC_WR   = 2'd2
    } cyc_t;

    typedef enum logic {
        ST_DESEL = 1'b0,
        ST_BURST = 1'b1
    } state_t;

    // low two address bits for burst step n from start
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] n,
                                            input logic       ilv);
        return ilv ? (start ^ n) : 2'(start + n);
    endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode #(
    parameter int LANES = 4
) (
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             wr_all_n,
    input  logic             wr_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             cmd_begin,
    output logic             cmd_desel,
    output logic             cmd_cont,
    output logic             wr_begin,
    output logic             wcond,
    output logic [LANES-1:0] lane_mask
);
    logic sel_ok;

    always_comb begin
        sel_ok    = !cs1_n && cs2 && !cs3_n;
        cmd_begin = sel_ok && (!proc_stb_n || !ctrl_stb_n);
        cmd_desel = !sel_ok && (!ctrl_stb_n || (!proc_stb_n && !cs1_n));
        cmd_cont  = proc_stb_n && ctrl_stb_n;
        if (!wr_all_n)
            lane_mask = '1;
        else if (!wr_gate_n)
            lane_mask = ~lane_wr_n;
        else
            lane_mask = '0;
        wcond    = |lane_mask;
        wr_begin = cmd_begin && proc_stb_n && wcond;
    end
endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              step,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      lo0_q;
    logic [1:0]      cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo0_q <= '0;
            cnt_q <= '0;
        end else if (en) begin
            if (load) begin
                hi_q  <= addr_in[ADDR_W-1:2];
                lo0_q <= addr_in[1:0];
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    always_comb begin
        cur_addr = {hi_q, burst_lo(lo0_q, cnt_q, ilv)};
        if (load)
            nxt_addr = addr_in;
        else if (step)
            nxt_addr = {hi_q, burst_lo(lo0_q, 2'(cnt_q + 2'd1), ilv)};
        else
            nxt_addr = cur_addr;
    end

    // R6
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && load) |=> $stable(hi_q));

    // R5
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !load) |=> cnt_q == 2'($past(cnt_q) + 2'd1));

    // R7
    load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> cnt_q == 2'd0);
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  lane_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = DATA_W / LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g])
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              wr_all_n,
    input  logic              wr_gate_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              oe_n,
    input  logic              burst_ilv,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);
    state_t state_q, state_n;
    cyc_t   cyc_q, cyc_n;

    logic              cmd_begin, cmd_desel, cmd_cont, wr_begin, wcond;
    logic [LANES-1:0]  lane_mask;
    logic              go, ctr_load, ctr_step, mem_we;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [DATA_W-1:0] mem_rd;

    assign go = !sleep;

    bsram_decode #(.LANES(LANES)) dec_i (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .wr_all_n   (wr_all_n),
        .wr_gate_n  (wr_gate_n),
        .lane_wr_n  (lane_wr_n),
        .cmd_begin  (cmd_begin),
        .cmd_desel  (cmd_desel),
        .cmd_cont   (cmd_cont),
        .wr_begin   (wr_begin),
        .wcond      (wcond),
        .lane_mask  (lane_mask)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            cyc_q   <= CYC_NONE;
        end else if (go) begin
            state_q <= state_n;
            cyc_q   <= cyc_n;
        end
    end

    // next state and control outputs
    always_comb begin
        state_n  = state_q;
        cyc_n    = CYC_NONE;
        ctr_step = 1'b0;
        unique case (state_q)
            ST_DESEL: begin
                if (cmd_begin) begin
                    state_n = ST_BURST;
                    cyc_n   = wr_begin ? CYC_WR : CYC_RD;
                end
            end
            ST_BURST: begin
                if (cmd_begin) begin
                    cyc_n = wr_begin ? CYC_WR : CYC_RD;
                end else if (cmd_desel) begin
                    state_n = ST_DESEL;
                end else if (cmd_cont) begin
                    cyc_n    = wcond ? CYC_WR : CYC_RD;
                    ctr_step = !adv_n;
                end
            end
            default: state_n = ST_DESEL;
        endcase
        ctr_load = cmd_begin;
        mem_we   = go && (cyc_n == CYC_WR);
    end

    bsram_burst_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (go),
        .load     (ctr_load),
        .step     (ctr_step),
        .ilv      (burst_ilv),
        .addr_in  (addr),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) mem_i (
        .clk     (clk),
        .we      (mem_we),
        .lane_en (lane_mask),
        .waddr   (nxt_addr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (mem_rd)
    );

    always_comb begin
        rd_valid = (cyc_q == CYC_RD) && !oe_n && !sleep;
        rdata    = rd_valid ? mem_rd : '0;
    end

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(state_q) && $stable(cyc_q) && $stable(cur_addr)));

    // R3
    desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd_desel) |=> (state_q == ST_DESEL && !rd_valid));

    // R2
    proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd_begin && !proc_stb_n) |=> cyc_q == CYC_RD);

    // R9
    wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mem_we) |=> !rd_valid);
endmodule

// File: tb/bsram_core_tb.sv
`timescale 1ns/1ps
module bsram_core_tb_top;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int LN = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          proc_stb_n, ctrl_stb_n, adv_n, cs1_n, cs2, cs3_n;
    logic          wr_all_n, wr_gate_n, oe_n, burst_ilv, sleep;
    logic [LN-1:0] lane_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          rd_valid;

    always #2.5 clk = ~clk;

    bsram_core #(.ADDR_W(AW), .DATA_W(DW), .LANES(LN)) dut_i (
        .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .burst_ilv(burst_ilv), .sleep(sleep), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model: 0 none, 1 read, 2 write
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_act;
    logic [AW-3:0] m_hi;
    logic [1:0]    m_lo0, m_cnt;
    int            m_cyc;

    function automatic logic [1:0] m_low(input logic [1:0] s, input logic [1:0] n, input logic ilv);
        return ilv ? (s ^ n) : 2'(s + n);
    endfunction

    function automatic logic [AW-1:0] m_addr();
        return {m_hi, m_low(m_lo0, m_cnt, burst_ilv)};
    endfunction

    function automatic logic [LN-1:0] m_mask();
        if (!wr_all_n) return '1;
        if (!wr_gate_n) return ~lane_wr_n;
        return '0;
    endfunction

    task automatic m_write(input logic [AW-1:0] a, input logic [LN-1:0] mk);
        for (int i = 0; i < LN; i++)
            if (mk[i]) m_mem[a][i*8 +: 8] = wdata[i*8 +: 8];
    endtask

    task automatic m_step();
        bit sel, beg, des;
        logic [LN-1:0] mk;
        if (sleep) return;
        sel = !cs1_n && cs2 && !cs3_n;
        beg = sel && (!proc_stb_n || !ctrl_stb_n);
        des = !sel && (!ctrl_stb_n || (!proc_stb_n && !cs1_n));
        mk  = m_mask();
        if (beg) begin
            m_act = 1'b1; m_hi = addr[AW-1:2]; m_lo0 = addr[1:0]; m_cnt = 2'd0;
            m_cyc = (proc_stb_n && (mk != '0)) ? 2 : 1;
            if (m_cyc == 2) m_write(m_addr(), mk);
        end else if (des) begin
            m_act = 1'b0; m_cyc = 0;
        end else if (proc_stb_n && ctrl_stb_n && m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            m_cyc = (mk != '0) ? 2 : 1;
            if (m_cyc == 2) m_write(m_addr(), mk);
        end else begin
            m_cyc = 0;
        end
    endtask

    task automatic chk(input string tag);
        bit e_v;
        logic [DW-1:0] e_d;
        e_v = (m_cyc == 1) && !oe_n && !sleep;
        e_d = e_v ? m_mem[m_addr()] : '0;
        n_chk++;
        if (rd_valid !== e_v) begin
            n_bad++;
            $display("FAIL %s rd_valid actual=%b expected=%b t=%0t", tag, rd_valid, e_v, $time);
        end
        n_chk++;
        if (rdata !== e_d) begin
            n_bad++;
            $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, rdata, e_d, $time);
        end
    endtask

    task automatic chk_val(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s value actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        m_step();
        @(posedge clk);
        #1;
        chk(tag);
    endtask

    task automatic idle();
        proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
        cs1_n = 0; cs2 = 1; cs3_n = 0;
        wr_all_n = 1; wr_gate_n = 1; lane_wr_n = '1;
        oe_n = 0; sleep = 0;
    endtask

    // directed burst order check: returns nothing, checks each step address
    task automatic order_check(input string tag, input logic ilv, input logic [AW-1:0] a);
        logic [AW-1:0] ea;
        burst_ilv = ilv;
        idle(); proc_stb_n = 0; addr = a;
        tick(tag);
        chk_val(tag, rdata, m_mem[a]);
        for (int n = 1; n < 4; n++) begin
            idle(); adv_n = 0;
            tick(tag);
            ea = {a[AW-1:2], ilv ? (a[1:0] ^ 2'(n)) : 2'(a[1:0] + 2'(n))};
            chk_val(tag, rdata, m_mem[ea]);
        end
    endtask

    initial begin
        int unsigned sd;
        logic [DW-1:0] old;
        sd = $urandom(32'd4711);
        idle(); burst_ilv = 0; addr = '0; wdata = '0; rst_n = 0;
        m_act = 0; m_hi = '0; m_lo0 = '0; m_cnt = '0; m_cyc = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        chk("R11");

        // fill the array with whole-word linear bursts (R1, R8)
        for (int b = 0; b < DEPTH; b += 4) begin
            idle(); ctrl_stb_n = 0; wr_all_n = 0; addr = AW'(b); wdata = $urandom;
            tick("R1");
            for (int k = 1; k < 4; k++) begin
                idle(); adv_n = 0; wr_all_n = 0; wdata = $urandom;
                tick("R8");
            end
        end

        // R7 interleaved and linear orders from low bits 01
        order_check("R7", 1'b1, 6'h15);
        order_check("R7", 1'b0, 6'h15);

        // R2: processor begin ignores write enables
        old = m_mem[6'h22];
        idle(); proc_stb_n = 0; wr_all_n = 0; addr = 6'h22; wdata = 32'hDEAD_BEEF;
        tick("R2");
        chk_val("R2", rdata, old);
        idle(); wr_all_n = 0;
        proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; wr_all_n = 1;
        tick("R2");
        chk_val("R2", rdata, old);

        // R8: lanes 0 and 2 through the byte gate
        old = m_mem[6'h09];
        idle(); ctrl_stb_n = 0; wr_gate_n = 0; lane_wr_n = 4'b1010; addr = 6'h09;
        wdata = 32'hA1B2_C3D4;
        tick("R8");
        idle(); proc_stb_n = 0; addr = 6'h09;
        tick("R8");
        chk_val("R8", rdata, {old[31:24], 8'hB2, old[15:8], 8'hD4});
        // gate low but no lane low: read, no change
        idle(); wr_gate_n = 0; lane_wr_n = '1; wdata = '1;
        tick("R8");
        chk_val("R8", rdata, {old[31:24], 8'hB2, old[15:8], 8'hD4});

        // R3: deselect via controller strobe while unselected, then continues
        idle(); ctrl_stb_n = 0; cs1_n = 1;
        tick("R3");
        for (int k = 0; k < 3; k++) begin
            idle(); adv_n = k[0];
            tick("R3");
            chk_val("R3", {31'd0, rd_valid}, '0);
        end
        // processor strobe with cs2 low deselects too
        idle(); proc_stb_n = 0; addr = 6'h30;
        tick("R1");
        idle(); proc_stb_n = 0; cs2 = 0;
        tick("R3");
        idle(); adv_n = 0;
        tick("R3");

        // R4: no-op keeps the burst position
        idle(); proc_stb_n = 0; addr = 6'h2C;
        tick("R4");
        idle(); proc_stb_n = 0; cs1_n = 1;
        tick("R4");
        idle(); adv_n = 0;
        tick("R4");
        chk_val("R4", rdata, m_mem[6'h2D]);

        // R5 and R6: advance and hold with chip selects dropped
        idle(); cs1_n = 1; cs2 = 0; cs3_n = 1; adv_n = 0;
        tick("R5");
        chk_val("R6", rdata, m_mem[6'h2E]);
        idle(); cs1_n = 1; adv_n = 1;
        tick("R5");
        chk_val("R5", rdata, m_mem[6'h2E]);

        // R10: commands while asleep are dropped
        idle(); sleep = 1; proc_stb_n = 0; addr = 6'h01;
        tick("R10");
        idle(); sleep = 1; adv_n = 0; ctrl_stb_n = 0; wr_all_n = 0; addr = 6'h02;
        tick("R10");
        idle(); adv_n = 0;
        tick("R10");
        chk_val("R10", rdata, m_mem[6'h2F]);

        // R9: output enable gating and write cycles
        idle(); oe_n = 1;
        tick("R9");
        idle(); wr_all_n = 0; wdata = 32'h1234_5678;
        tick("R9");
        idle();
        tick("R9");
        chk_val("R9", rdata, 32'h1234_5678);

        // random phase, both orders
        for (int ph = 0; ph < 2; ph++) begin
            burst_ilv = ph[0];
            for (int c = 0; c < 1500; c++) begin
                proc_stb_n = ($urandom_range(0, 9) != 0);
                ctrl_stb_n = ($urandom_range(0, 4) != 0);
                adv_n      = ($urandom_range(0, 9) > 5);
                cs1_n      = ($urandom_range(0, 9) == 0);
                cs2        = ($urandom_range(0, 9) != 0);
                cs3_n      = ($urandom_range(0, 9) == 0);
                wr_all_n   = ($urandom_range(0, 9) > 1);
                wr_gate_n  = ($urandom_range(0, 9) > 4);
                lane_wr_n  = LN'($urandom);
                oe_n       = ($urandom_range(0, 9) == 0);
                sleep      = ($urandom_range(0, 11) == 0);
                addr       = AW'($urandom);
                wdata      = $urandom;
                tick("R9");
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule